// File: doc/BRIEF.md
# Remappable Memory Map Decoder

This block turns a 16-bit CPU address into a single chip select for one of six targets: internal RAM, the peripheral register block, EEPROM, main ROM, boot ROM or the external bus. A mapping register places the 256-byte RAM and the 64-byte register block on any 4 KB page while the chip is running. Where these regions overlap, a fixed priority decides which target is selected.

Two mode pins are captured once after reset and give three control bits. These bits choose how the map behaves. They decide whether the boot ROM is visible and whether unmatched addresses go to the external bus. They decide whether vector fetches are moved to the special-mode vector area. They also set the rules for writing the mapping register. Two enable inputs from a configuration register switch EEPROM and ROM in or out of the map.

The chip selects and the effective address are combinational in `addr_i`. Only the mode bits and the mapping register are held in flops.

Top module: `mem_map_decoder`

## Requirements
- R1: RAM occupies 256 bytes starting at page `map_o[7:4]` (address bits 15:12). After reset this page is 0, so RAM sits at 0x0000–0x00FF.
- R2: The register block occupies 64 bytes starting at page `map_o[3:0]`. `map_o` resets to 0x01, so the register block sits at 0x1000–0x103F.
- R3: Overlap priority runs from highest to lowest: register block, RAM, boot ROM, EEPROM, ROM, external. Only one select is active at a time.
- R4: In the normal modes (`mode_o[1]`=0), a mapping write is `map_we_i` together with `bus_cycle_i`. It is accepted only if it is the first accepted write and falls within the first 64 bus cycles after reset (cycles counted by `bus_cycle_i`). Any later write leaves `map_o` unchanged.
- R5: In the special modes (`mode_o[1]`=1), every mapping write is accepted, at any time.
- R6: EEPROM is selected at 0xB600–0xB7FF only when `ee_en_i`=1. ROM is selected at 0xE000–0xFFFF when `rom_en_i`=1, and always in single-chip mode.
- R7: Boot ROM is selected at 0xBF40–0xBFFF only when the boot bit `mode_o[2]` is 1.
- R8: On the first clock after reset release, `mode_o` = {boot, special, mode-A} takes these values. Pins (b,a)=(1,0) give 000 (single-chip). (1,1) give 001 (expanded). (0,0) give 110 (bootstrap). (0,1) give 011 (test). The value then holds until the next reset.
- R9: When `mode_o[1]`=1, addresses 0xFFC0–0xFFFF are redirected to 0xBFC0–0xBFFF: `eff_addr_o` holds the redirected address, and decoding uses it. In all other cases `eff_addr_o` equals `addr_i`.
- R10: `cs_o` bit order is [0] RAM, [1] register block, [2] EEPROM, [3] ROM, [4] boot ROM, [5] external. An address that hits no enabled internal target sets bit 5 when `mode_o[0]`=1. When `mode_o[0]`=0, such an address leaves `cs_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_b_i | input | 1 | Mode pin B, captured after reset |
| mode_a_i | input | 1 | Mode pin A, captured after reset |
| ee_en_i | input | 1 | EEPROM enable from the configuration register |
| rom_en_i | input | 1 | ROM enable from the configuration register |
| addr_i | input | 16 | CPU address |
| bus_cycle_i | input | 1 | High for one clock per bus cycle |
| map_we_i | input | 1 | Mapping register write strobe |
| map_wdata_i | input | 8 | Mapping write data: {RAM page, register page} |
| cs_o | output | 6 | One-hot chip selects |
| eff_addr_o | output | 16 | Address after vector redirection |
| map_o | output | 8 | Current mapping register value |
| mode_o | output | 3 | Latched {boot, special, mode-A} |

## Verification
Relocation and overlap priority act together in the same cycle. When the mapping register places the register block and RAM on the same page, and that page also holds ROM, a single address hits three regions at once. To provoke this, the bench writes the mapping register with equal and neighbouring page pairs on all 16 pages in test mode, then probes addresses at the base, at the last register byte, at the first byte above it and at the end of RAM. A reference model built from the requirements judges each result.

Vector redirection and the boot ROM window also meet in one cycle. In bootstrap mode a vector address must both be redirected and land in the boot ROM. In test mode the same address ends on the external bus.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;
  localparam int unsigned NCS = 6;

  typedef enum int unsigned {
    CS_RAM  = 0,
    CS_REG  = 1,
    CS_EE   = 2,
    CS_ROM  = 3,
    CS_BOOT = 4,
    CS_EXT  = 5
  } cs_idx_e;

  typedef struct packed {
    logic boot;
    logic special;
    logic mda;
  } mode_t;
endpackage

// File: rtl/mem_map_mode_latch.sv
module mem_map_mode_latch
  import mem_map_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_b_i,
  input  logic  mode_a_i,
  output mode_t mode_o
);
  logic  done_q;
  mode_t mode_q;

  // capture pins once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mode_q <= '0;
    end else if (!done_q) begin
      done_q          <= 1'b1;
      mode_q.boot     <= !mode_b_i && !mode_a_i;
      mode_q.special  <= !mode_b_i;
      mode_q.mda      <= mode_a_i;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/mem_map_reg.sv
module mem_map_reg #(
  parameter int unsigned       PW      = 4,
  parameter int unsigned       WIN     = 64,
  parameter logic [2*PW-1:0]   RST_VAL = 8'h01
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            special_i,
  input  logic            bus_cycle_i,
  input  logic            we_i,
  input  logic [2*PW-1:0] wdata_i,
  output logic [2*PW-1:0] map_o
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);

  logic [CW-1:0]   cnt_q;
  logic            used_q;
  logic [2*PW-1:0] map_q;
  logic            open_w, take_w;

  assign open_w = special_i || (!used_q && (cnt_q < WIN_C));
  assign take_w = we_i && bus_cycle_i && open_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      used_q <= 1'b0;
      map_q  <= RST_VAL;
    end else begin
      if (bus_cycle_i && (cnt_q < WIN_C)) cnt_q <= cnt_q + 1'b1;
      if (take_w) begin
        used_q <= 1'b1;
        map_q  <= wdata_i;
      end
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/mem_map_region_dec.sv
module mem_map_region_dec
  import mem_map_pkg::*;
#(
  parameter int unsigned       AW       = 16,
  parameter int unsigned       PW       = 4,
  parameter int unsigned       RAM_AW   = 8,
  parameter int unsigned       REG_AW   = 6,
  parameter logic [AW-1:0]     EE_LO    = 16'hB600,
  parameter logic [AW-1:0]     EE_HI    = 16'hB7FF,
  parameter logic [AW-1:0]     ROM_LO   = 16'hE000,
  parameter logic [AW-1:0]     BOOT_LO  = 16'hBF40,
  parameter logic [AW-1:0]     BOOT_HI  = 16'hBFFF,
  parameter logic [AW-1:0]     VEC_LO   = 16'hFFC0,
  parameter logic [AW-1:0]     VEC_FLIP = 16'h4000
) (
  input  logic [AW-1:0]  addr_i,
  input  mode_t          mode_i,
  input  logic           ee_en_i,
  input  logic           rom_en_i,
  input  logic [PW-1:0]  ram_pg_i,
  input  logic [PW-1:0]  reg_pg_i,
  output logic [NCS-1:0] cs_o,
  output logic [AW-1:0]  eff_o
);
  logic [AW-1:0] eff;
  logic [PW-1:0] pg;
  logic ram_hit, reg_hit, ee_hit, rom_hit, boot_hit, single;

  assign single = !mode_i.special && !mode_i.mda;
  assign eff    = (mode_i.special && addr_i >= VEC_LO) ? (addr_i ^ VEC_FLIP) : addr_i;
  assign pg     = eff[AW-1 -: PW];

  assign reg_hit  = (pg == reg_pg_i) && (eff[AW-PW-1:REG_AW] == '0);
  assign ram_hit  = (pg == ram_pg_i) && (eff[AW-PW-1:RAM_AW] == '0);
  assign boot_hit = mode_i.boot && (eff >= BOOT_LO) && (eff <= BOOT_HI);
  assign ee_hit   = ee_en_i && (eff >= EE_LO) && (eff <= EE_HI);
  assign rom_hit  = (rom_en_i || single) && (eff >= ROM_LO);

  always_comb begin
    cs_o = '0;
    if      (reg_hit)     cs_o[CS_REG]  = 1'b1;
    else if (ram_hit)     cs_o[CS_RAM]  = 1'b1;
    else if (boot_hit)    cs_o[CS_BOOT] = 1'b1;
    else if (ee_hit)      cs_o[CS_EE]   = 1'b1;
    else if (rom_hit)     cs_o[CS_ROM]  = 1'b1;
    else if (mode_i.mda)  cs_o[CS_EXT]  = 1'b1;
  end

  assign eff_o = eff;
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mem_map_pkg::*;
#(
  parameter int unsigned     AW      = 16,
  parameter int unsigned     PW      = 4,
  parameter int unsigned     WIN     = 64,
  parameter logic [2*PW-1:0] MAP_RST = 8'h01
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_b_i,
  input  logic            mode_a_i,
  input  logic            ee_en_i,
  input  logic            rom_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            bus_cycle_i,
  input  logic            map_we_i,
  input  logic [2*PW-1:0] map_wdata_i,
  output logic [NCS-1:0]  cs_o,
  output logic [AW-1:0]   eff_addr_o,
  output logic [2*PW-1:0] map_o,
  output logic [2:0]      mode_o
);
  mode_t           mode_w;
  logic [2*PW-1:0] map_w;

  mem_map_mode_latch u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_b_i (mode_b_i),
    .mode_a_i (mode_a_i),
    .mode_o   (mode_w)
  );

  mem_map_reg #(.PW(PW), .WIN(WIN), .RST_VAL(MAP_RST)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .special_i   (mode_w.special),
    .bus_cycle_i (bus_cycle_i),
    .we_i        (map_we_i),
    .wdata_i     (map_wdata_i),
    .map_o       (map_w)
  );

  mem_map_region_dec #(.AW(AW), .PW(PW)) u_dec (
    .addr_i   (addr_i),
    .mode_i   (mode_w),
    .ee_en_i  (ee_en_i),
    .rom_en_i (rom_en_i),
    .ram_pg_i (map_w[2*PW-1:PW]),
    .reg_pg_i (map_w[PW-1:0]),
    .cs_o     (cs_o),
    .eff_o    (eff_addr_o)
  );

  assign map_o  = map_w;
  assign mode_o = mode_w;
endmodule

// File: rtl/mem_map_checker.sv
module mem_map_checker #(
  parameter int unsigned AW  = 16,
  parameter int unsigned PW  = 4,
  parameter int unsigned WIN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            bus_cycle_i,
  input logic [5:0]      cs_o,
  input logic [AW-1:0]   eff_addr_o,
  input logic [2*PW-1:0] map_o,
  input logic [2:0]      mode_o
);
  localparam int unsigned CW = $clog2(WIN + 1);
  logic [CW-1:0] n_q;
  logic          started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q       <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (bus_cycle_i && n_q < CW'(WIN)) n_q <= n_q + 1'b1;
    end
  end

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  p_reg_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_addr_o[AW-1 -: PW] == map_o[PW-1:0] && eff_addr_o[AW-PW-1:6] == '0)
      |-> cs_o == 6'b000010);

  p_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o[1] && n_q == CW'(WIN)) |=> $stable(map_o));

  p_vec_redirect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && addr_i >= 16'hFFC0) |-> eff_addr_o == (addr_i ^ 16'h4000));

  p_no_ext_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[0] |-> !cs_o[5]);

  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> $stable(mode_o));
endmodule

bind mem_map_decoder mem_map_checker #(.AW(AW), .PW(PW), .WIN(WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .bus_cycle_i (bus_cycle_i),
  .cs_o        (cs_o),
  .eff_addr_o  (eff_addr_o),
  .map_o       (map_o),
  .mode_o      (mode_o)
);

// File: tb/mem_map_decoder_tb.sv
module mem_map_decoder_tb;
  localparam int CLK_P = 10;
  localparam logic [5:0] C_RAM = 6'b000001, C_REG = 6'b000010, C_EE = 6'b000100,
                         C_ROM = 6'b001000, C_BOOT = 6'b010000, C_EXT = 6'b100000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_b_i = 1'b1, mode_a_i = 1'b1, ee_en_i = 1'b0, rom_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic bus_cycle_i = 1'b0, map_we_i = 1'b0;
  logic [7:0] map_wdata_i = '0;
  logic [5:0] cs_o;
  logic [15:0] eff_addr_o;
  logic [7:0] map_o;
  logic [2:0] mode_o;

  always #(CLK_P/2) clk = ~clk;

  mem_map_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_b_i(mode_b_i), .mode_a_i(mode_a_i),
    .ee_en_i(ee_en_i), .rom_en_i(rom_en_i), .addr_i(addr_i),
    .bus_cycle_i(bus_cycle_i), .map_we_i(map_we_i), .map_wdata_i(map_wdata_i),
    .cs_o(cs_o), .eff_addr_o(eff_addr_o), .map_o(map_o), .mode_o(mode_o)
  );

  typedef struct {
    logic [15:0] a;
    logic [5:0]  cs;
    logic [15:0] eff;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [7:0] map_m;
  logic [2:0] mode_m;

  function automatic logic [15:0] m_eff(input logic [15:0] a);
    return (mode_m[1] && a >= 16'hFFC0) ? {2'b10, a[13:0]} : a;
  endfunction

  function automatic logic [5:0] m_cs(input logic [15:0] a);
    logic [15:0] e;
    e = m_eff(a);
    if (e[15:12] == map_m[3:0] && e[11:6] == 6'd0) return C_REG;
    if (e[15:12] == map_m[7:4] && e[11:8] == 4'd0) return C_RAM;
    if (mode_m[2] && e >= 16'hBF40 && e <= 16'hBFFF) return C_BOOT;
    if (ee_en_i && e >= 16'hB600 && e <= 16'hB7FF) return C_EE;
    if ((rom_en_i || mode_m == 3'b000) && e >= 16'hE000) return C_ROM;
    if (mode_m[0]) return C_EXT;
    return 6'b0;
  endfunction

  task automatic push(input logic [15:0] a, input logic [5:0] cs,
                      input logic [15:0] eff, input string tag);
    exp_t e;
    @(negedge clk);
    addr_i = a;
    e.a = a; e.cs = cs; e.eff = eff; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic probe_m(input logic [15:0] a, input string tag);
    push(a, m_cs(a), m_eff(a), tag);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (cs_o !== e.cs || eff_addr_o !== e.eff) begin
          errors++;
          $display("FAIL %s addr=%h act cs=%b eff=%h exp cs=%b eff=%h",
                   e.tag, e.a, cs_o, eff_addr_o, e.cs, e.eff);
        end
      end
    end
  end

  task automatic do_reset(input logic mb, input logic ma, input logic [2:0] exp_mode);
    @(negedge clk);
    rst_ni = 1'b0; mode_b_i = mb; mode_a_i = ma;
    map_we_i = 1'b0; bus_cycle_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    mode_m = exp_mode;
    map_m  = 8'h01;
    chk({5'd0, mode_o}, {5'd0, exp_mode}, "R8 mode capture");
    chk(map_o, 8'h01, "R2 map reset value");
  endtask

  task automatic wr_map(input logic [7:0] v, input logic ok);
    @(negedge clk);
    map_we_i = 1'b1; bus_cycle_i = 1'b1; map_wdata_i = v;
    @(negedge clk);
    map_we_i = 1'b0; bus_cycle_i = 1'b0;
    if (ok) map_m = v;
  endtask

  task automatic idle_bus(input int n);
    @(negedge clk);
    bus_cycle_i = 1'b1;
    repeat (n) @(negedge clk);
    bus_cycle_i = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    // expanded mode
    do_reset(1'b1, 1'b1, 3'b001);
    push(16'h0000, C_RAM, 16'h0000, "R1 ram low");
    push(16'h00FF, C_RAM, 16'h00FF, "R1 ram high");
    push(16'h0100, C_EXT, 16'h0100, "R10 above ram");
    push(16'h1000, C_REG, 16'h1000, "R2 reg low");
    push(16'h103F, C_REG, 16'h103F, "R2 reg high");
    push(16'h1040, C_EXT, 16'h1040, "R10 above reg");
    ee_en_i = 1'b1;
    push(16'hB600, C_EE, 16'hB600, "R6 ee low");
    push(16'hB7FF, C_EE, 16'hB7FF, "R6 ee high");
    push(16'hB800, C_EXT, 16'hB800, "R6 ee end");
    push(16'hBF40, C_EXT, 16'hBF40, "R7 no boot in expanded");
    push(16'hFFC0, C_EXT, 16'hFFC0, "R9 no redirect normal");
    @(negedge clk); ee_en_i = 1'b0;
    push(16'hB600, C_EXT, 16'hB600, "R6 ee disabled");
    push(16'hE000, C_EXT, 16'hE000, "R6 rom disabled");
    @(negedge clk); rom_en_i = 1'b1;
    push(16'hE000, C_ROM, 16'hE000, "R6 rom enabled");
    wr_map(8'h33, 1'b1);
    chk(map_o, 8'h33, "R4 first write in window");
    push(16'h3000, C_REG, 16'h3000, "R3 reg over ram");
    push(16'h303F, C_REG, 16'h303F, "R3 reg over ram top");
    push(16'h3040, C_RAM, 16'h3040, "R3 ram below reg");
    push(16'h30FF, C_RAM, 16'h30FF, "R3 ram end");
    push(16'h0000, C_EXT, 16'h0000, "R1 old ram page empty");
    wr_map(8'h55, 1'b0);
    chk(map_o, 8'h33, "R4 second write ignored");
    push(16'h5000, C_EXT, 16'h5000, "R4 ignored page not mapped");

    // window boundary: 64th bus cycle accepted
    do_reset(1'b1, 1'b1, 3'b001);
    idle_bus(63);
    wr_map(8'h22, 1'b1);
    chk(map_o, 8'h22, "R4 write on 64th bus cycle");
    // window boundary: 65th bus cycle ignored
    do_reset(1'b1, 1'b1, 3'b001);
    idle_bus(64);
    wr_map(8'h77, 1'b0);
    chk(map_o, 8'h01, "R4 write after window ignored");
    push(16'h7000, C_EXT, 16'h7000, "R4 late page not mapped");

    // test mode: sweep all pages
    do_reset(1'b0, 1'b1, 3'b011);
    ee_en_i = 1'b1; rom_en_i = 1'b1;
    idle_bus(70);
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pg, pn;
      pg = 4'(p);
      pn = pg ^ 4'h1;
      wr_map({pg, pg}, 1'b1);
      chk(map_o, {pg, pg}, "R5 special write any time");
      probe_m({pg, 12'h000}, "R3 sweep base");
      probe_m({pg, 12'h03F}, "R3 sweep reg top");
      probe_m({pg, 12'h040}, "R3 sweep ram above reg");
      probe_m({pg, 12'h0FF}, "R1 sweep ram top");
      probe_m({pg, 12'h100}, "R10 sweep above");
      wr_map({pg, pn}, 1'b1);
      probe_m({pg, 12'h000}, "R1 sweep ram base");
      probe_m({pn, 12'h000}, "R2 sweep reg base");
      probe_m({pn, 12'h040}, "R2 sweep reg end");
    end
    wr_map(8'hE1, 1'b1);
    push(16'hE000, C_RAM, 16'hE000, "R3 ram over rom");
    push(16'hE100, C_ROM, 16'hE100, "R6 rom past ram");
    push(16'hFFC0, C_EXT, 16'hBFC0, "R9 redirect test mode");
    push(16'hFFFF, C_EXT, 16'hBFFF, "R9 redirect top");
    push(16'hBF40, C_EXT, 16'hBF40, "R7 no boot in test");

    // bootstrap mode
    do_reset(1'b0, 1'b0, 3'b110);
    ee_en_i = 1'b0; rom_en_i = 1'b0;
    push(16'hBF40, C_BOOT, 16'hBF40, "R7 boot low");
    push(16'hBFFF, C_BOOT, 16'hBFFF, "R7 boot high");
    push(16'hBF3F, 6'b0, 16'hBF3F, "R10 below boot no ext");
    push(16'hFFFE, C_BOOT, 16'hBFFE, "R9 vector to boot");
    push(16'h4000, 6'b0, 16'h4000, "R10 no ext bootstrap");
    idle_bus(70);
    wr_map(8'h42, 1'b1);
    chk(map_o, 8'h42, "R5 late write accepted");
    wr_map(8'hB2, 1'b1);
    chk(map_o, 8'hB2, "R5 repeat write accepted");
    push(16'hBF40, C_BOOT, 16'hBF40, "R3 boot outside ram");
    push(16'hB000, C_RAM, 16'hB000, "R3 ram page b");

    // single-chip mode
    do_reset(1'b1, 1'b0, 3'b000);
    push(16'hE000, C_ROM, 16'hE000, "R6 rom forced single-chip");
    push(16'hFFC0, C_ROM, 16'hFFC0, "R9 no redirect single-chip");
    push(16'h4000, 6'b0, 16'h4000, "R10 unmatched single-chip");
    push(16'h0010, C_RAM, 16'h0010, "R1 ram single-chip");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule